// File: doc/BRIEF.md
# DMA Fault Status Tracker

This block records fault conditions for a DMA engine with one manager thread and a parameterized number of channel threads (eight by default). Each thread reports a fault as a single-cycle pulse carrying a fault-type code. The block keeps, per thread, a fault-type register that accumulates one bit per reported code. It also keeps a summary bit per channel and one summary bit for the manager. A single abort interrupt tells the system that the engine holds at least one outstanding fault.

Each channel runs a small state machine with three named states. `CH_OK` means no fault. `CH_FAULT` means faulting. `CH_FAULT_CMPL` means faulting while completing. Transitions:
- OK→FAULT: a fault pulse arrives with the completing flag low.
- OK→FAULT_CMPL, FAULT→FAULT_CMPL: a fault pulse arrives with the completing flag high.
- FAULT_CMPL→FAULT, FAULT→FAULT: a fault pulse arrives with the flag low.
- FAULT/FAULT_CMPL→OK: a kill request arrives with no fault pulse in the same cycle.

The manager has two states, `MGR_OK` and `MGR_FAULT`. It enters MGR_FAULT on a manager fault pulse and leaves only through reset.

The abort controller has two states, `AB_IDLE` and `AB_RAISED`. It goes IDLE→RAISED on a fault pulse that arrives while no summary bit is set. It goes RAISED→IDLE on an effective kill that leaves no channel and no manager fault pending.

All registers update on the rising clock edge. The read ports and status outputs are driven combinationally from the registers, so the effect of an input pulse is visible one cycle later.

Top module: `dft_fault_tracker`

## Requirements
- R1: A fault pulse on channel c with code k sets bit k of channel c's fault-type register on the next edge. Bits already set are kept.
- R2: A channel fault puts the channel in a faulting state on the next edge. If the completing flag is high, the state is faulting-while-completing and `ch_cmpl_state[c]` goes high; if the flag is low, `ch_cmpl_state[c]` is low. `ch_faulting[c]` and bit c of `ch_sum` go high either way.
- R3: A manager fault pulse with code k sets bit k of `mgr_ftype` and raises `mgr_sum` and `mgr_faulting` on the next edge. The manager stays faulting until reset.
- R4: `abort_irq` rises one cycle after a fault pulse (channel or manager) that arrives while all channel summary bits and the manager summary bit are clear.
- R5: A kill on a channel in either faulting state, with no fault pulse on that channel in the same cycle, clears that channel's fault-type register, its summary bit, `ch_faulting[c]` and `ch_cmpl_state[c]` on the next edge.
- R6: `abort_irq` falls one cycle after a kill that leaves no channel or manager fault pending. Otherwise it stays high.
- R7: While reset (`rst_n` low) is held, all fault-type registers, summary bits, state outputs and `abort_irq` are zero.
- R8: If a fault pulse and a kill reach the same channel in the same cycle, the fault is applied and the kill is dropped.
- R9: A kill on a channel that is not faulting leaves every register and output unchanged.
- R10: `ch_rd_ftype` shows the fault-type register of the channel chosen by `ch_rd_sel`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_fault_vld | input | NUM_CH | Per-channel fault pulse |
| ch_fault_code | input | NUM_CH*CODE_W | Fault code per channel; channel c uses bits [c*CODE_W +: CODE_W] |
| ch_fault_cmpl | input | NUM_CH | Fault occurred while the channel was completing |
| ch_kill | input | NUM_CH | Per-channel kill request |
| mgr_fault_vld | input | 1 | Manager fault pulse |
| mgr_fault_code | input | CODE_W | Manager fault code |
| ch_rd_sel | input | CH_IDX_W | Channel picked for the read port |
| ch_rd_ftype | output | FT_W | Fault-type register of the selected channel |
| ch_sum | output | NUM_CH | Channel fault summary, bit c for channel c |
| ch_faulting | output | NUM_CH | Channel is in either faulting state |
| ch_cmpl_state | output | NUM_CH | Channel is faulting while completing |
| mgr_ftype | output | FT_W | Manager fault-type register |
| mgr_sum | output | 1 | Manager fault summary bit |
| mgr_faulting | output | 1 | Manager is faulting |
| abort_irq | output | 1 | Abort interrupt |

## Verification
A wrong channel state shows on `ch_faulting`, `ch_cmpl_state` and `ch_sum` one cycle after the pulse that caused it. A lost or extra fault-type bit shows on `ch_rd_ftype` when that channel is selected. The abort controller and the summary bits are separate pieces of state, so a missed raise or a wrong drop appears as a mismatch between `abort_irq` and the summaries in the cycle after the event. The sharpest cases are a fault and a kill arriving together, and the last kill, which must clear the interrupt.

// File: rtl/dft_pkg.sv
package dft_pkg;
    typedef enum logic [1:0] {
        CH_OK         = 2'd0,
        CH_FAULT      = 2'd1,
        CH_FAULT_CMPL = 2'd2
    } ch_state_t;

    typedef enum logic {
        MGR_OK    = 1'b0,
        MGR_FAULT = 1'b1
    } mgr_state_t;

    typedef enum logic {
        AB_IDLE   = 1'b0,
        AB_RAISED = 1'b1
    } ab_state_t;
endpackage

// File: rtl/dft_ch_slot.sv
module dft_ch_slot
    import dft_pkg::*;
#(
    parameter int FT_W   = 32,
    parameter int CODE_W = $clog2(FT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_vld,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              fault_cmpl,
    input  logic              kill,
    output logic [FT_W-1:0]   ftype,
    output logic              faulting,
    output logic              cmpl_state,
    output logic              kill_done
);
    ch_state_t       state_q, state_n;
    logic [FT_W-1:0] ftype_q, ftype_n;

    // next-state and fault-type update
    always_comb begin
        state_n   = state_q;
        ftype_n   = ftype_q;
        kill_done = 1'b0;
        unique case (state_q)
            CH_OK: begin
                if (fault_vld) begin
                    ftype_n = ftype_q | (FT_W'(1) << fault_code);
                    state_n = fault_cmpl ? CH_FAULT_CMPL : CH_FAULT;
                end
            end
            CH_FAULT, CH_FAULT_CMPL: begin
                if (fault_vld) begin
                    ftype_n = ftype_q | (FT_W'(1) << fault_code);
                    state_n = fault_cmpl ? CH_FAULT_CMPL : CH_FAULT;
                end else if (kill) begin
                    ftype_n   = '0;
                    state_n   = CH_OK;
                    kill_done = 1'b1;
                end
            end
            default: begin
                ftype_n = '0;
                state_n = CH_OK;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OK;
            ftype_q <= '0;
        end else begin
            state_q <= state_n;
            ftype_q <= ftype_n;
        end
    end

    // outputs
    always_comb begin
        ftype      = ftype_q;
        faulting   = (state_q != CH_OK);
        cmpl_state = (state_q == CH_FAULT_CMPL);
    end

    AST_CH_FAULT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> ftype[$past(fault_code)] && faulting); // R1
    AST_CH_FAULT_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> ((ftype & $past(ftype)) == $past(ftype))); // R1
    AST_CH_CMPL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> (cmpl_state == $past(fault_cmpl))); // R2
    AST_CH_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !fault_vld && faulting) |=> (ftype == '0) && !faulting); // R5
    AST_CH_FAULT_BEATS_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && fault_vld) |=> faulting); // R8
    AST_CH_IDLE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !fault_vld && !faulting) |=> $stable(ftype) && !faulting); // R9
endmodule

// File: rtl/dft_mgr_slot.sv
module dft_mgr_slot
    import dft_pkg::*;
#(
    parameter int FT_W   = 32,
    parameter int CODE_W = $clog2(FT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_vld,
    input  logic [CODE_W-1:0] fault_code,
    output logic [FT_W-1:0]   ftype,
    output logic              faulting
);
    mgr_state_t      state_q, state_n;
    logic [FT_W-1:0] ftype_q, ftype_n;

    always_comb begin
        state_n = state_q;
        ftype_n = ftype_q;
        unique case (state_q)
            MGR_OK, MGR_FAULT: begin
                if (fault_vld) begin
                    ftype_n = ftype_q | (FT_W'(1) << fault_code);
                    state_n = MGR_FAULT;
                end
            end
            default: state_n = MGR_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MGR_OK;
            ftype_q <= '0;
        end else begin
            state_q <= state_n;
            ftype_q <= ftype_n;
        end
    end

    always_comb begin
        ftype    = ftype_q;
        faulting = (state_q == MGR_FAULT);
    end

    AST_MGR_FAULT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> ftype[$past(fault_code)] && faulting); // R3
    AST_MGR_STAYS_FAULTING: assert property (@(posedge clk) disable iff (!rst_n)
        faulting |=> faulting); // R3
endmodule

// File: rtl/dft_abort_ctl.sv
module dft_abort_ctl
    import dft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_any,
    input  logic kill_any,
    input  logic pend_now,
    input  logic pend_next,
    output logic abort_irq
);
    ab_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            AB_IDLE:   if (fault_any && !pend_now) state_n = AB_RAISED;
            AB_RAISED: if (kill_any && !pend_next) state_n = AB_IDLE;
            default:   state_n = AB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AB_IDLE;
        else        state_q <= state_n;
    end

    always_comb abort_irq = (state_q == AB_RAISED);

    AST_ABORT_FIRST_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_any && !pend_now) |=> abort_irq); // R4
    AST_ABORT_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq == pend_now); // R6
endmodule

// File: rtl/dft_fault_tracker.sv
module dft_fault_tracker
    import dft_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int FT_W     = 32,
    parameter int CODE_W   = $clog2(FT_W),
    parameter int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_fault_vld,
    input  logic [NUM_CH*CODE_W-1:0] ch_fault_code,
    input  logic [NUM_CH-1:0]        ch_fault_cmpl,
    input  logic [NUM_CH-1:0]        ch_kill,
    input  logic                     mgr_fault_vld,
    input  logic [CODE_W-1:0]        mgr_fault_code,
    input  logic [CH_IDX_W-1:0]      ch_rd_sel,
    output logic [FT_W-1:0]          ch_rd_ftype,
    output logic [NUM_CH-1:0]        ch_sum,
    output logic [NUM_CH-1:0]        ch_faulting,
    output logic [NUM_CH-1:0]        ch_cmpl_state,
    output logic [FT_W-1:0]          mgr_ftype,
    output logic                     mgr_sum,
    output logic                     mgr_faulting,
    output logic                     abort_irq
);
    logic [FT_W-1:0]   ch_ftype [NUM_CH];
    logic [NUM_CH-1:0] ch_kill_done;
    logic [NUM_CH-1:0] ch_pend_next;
    logic              pend_now, pend_next;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dft_ch_slot #(.FT_W(FT_W), .CODE_W(CODE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .fault_vld  (ch_fault_vld[c]),
            .fault_code (ch_fault_code[c*CODE_W +: CODE_W]),
            .fault_cmpl (ch_fault_cmpl[c]),
            .kill       (ch_kill[c]),
            .ftype      (ch_ftype[c]),
            .faulting   (ch_faulting[c]),
            .cmpl_state (ch_cmpl_state[c]),
            .kill_done  (ch_kill_done[c])
        );
        assign ch_pend_next[c] = ch_fault_vld[c] | (ch_faulting[c] & ~ch_kill_done[c]);
    end

    dft_mgr_slot #(.FT_W(FT_W), .CODE_W(CODE_W)) u_mgr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_vld  (mgr_fault_vld),
        .fault_code (mgr_fault_code),
        .ftype      (mgr_ftype),
        .faulting   (mgr_faulting)
    );

    always_comb begin
        ch_sum    = ch_faulting;
        mgr_sum   = mgr_faulting;
        pend_now  = (|ch_faulting) | mgr_faulting;
        pend_next = (|ch_pend_next) | mgr_fault_vld | mgr_faulting;
    end

    dft_abort_ctl u_abort (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_any ((|ch_fault_vld) | mgr_fault_vld),
        .kill_any  (|ch_kill_done),
        .pend_now  (pend_now),
        .pend_next (pend_next),
        .abort_irq (abort_irq)
    );

    always_comb begin
        ch_rd_ftype = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (CH_IDX_W'(c) == ch_rd_sel) ch_rd_ftype = ch_ftype[c];
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (ch_sum == '0) && !mgr_sum && !abort_irq); // R7
endmodule

// File: tb/dft_fault_tracker_tb.sv
`timescale 1ns/1ps
module dft_fault_tracker_tb;
    localparam int NUM_CH = 8;
    localparam int FT_W   = 32;
    localparam int CODE_W = 5;
    localparam int IDX_W  = 3;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NUM_CH-1:0]        ch_fault_vld, ch_fault_cmpl, ch_kill;
    logic [NUM_CH*CODE_W-1:0] ch_fault_code;
    logic                     mgr_fault_vld;
    logic [CODE_W-1:0]        mgr_fault_code;
    logic [IDX_W-1:0]         ch_rd_sel;
    logic [FT_W-1:0]          ch_rd_ftype, mgr_ftype;
    logic [NUM_CH-1:0]        ch_sum, ch_faulting, ch_cmpl_state;
    logic                     mgr_sum, mgr_faulting, abort_irq;

    int checks = 0;
    int errors = 0;

    // model: state 0 ok, 1 faulting, 2 faulting while completing
    logic [FT_W-1:0] m_ft [NUM_CH];
    int              m_st [NUM_CH];
    logic [FT_W-1:0] m_mft;
    logic            m_mgr, m_abort;

    always #2.5 clk = ~clk;

    dft_fault_tracker #(.NUM_CH(NUM_CH), .FT_W(FT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ch_fault_vld(ch_fault_vld), .ch_fault_code(ch_fault_code),
        .ch_fault_cmpl(ch_fault_cmpl), .ch_kill(ch_kill),
        .mgr_fault_vld(mgr_fault_vld), .mgr_fault_code(mgr_fault_code),
        .ch_rd_sel(ch_rd_sel), .ch_rd_ftype(ch_rd_ftype),
        .ch_sum(ch_sum), .ch_faulting(ch_faulting), .ch_cmpl_state(ch_cmpl_state),
        .mgr_ftype(mgr_ftype), .mgr_sum(mgr_sum), .mgr_faulting(mgr_faulting),
        .abort_irq(abort_irq)
    );

    function automatic logic [NUM_CH-1:0] model_sum();
        logic [NUM_CH-1:0] s;
        for (int c = 0; c < NUM_CH; c++) s[c] = (m_st[c] != 0);
        return s;
    endfunction

    function automatic logic [NUM_CH-1:0] model_cmpl();
        logic [NUM_CH-1:0] s;
        for (int c = 0; c < NUM_CH; c++) s[c] = (m_st[c] == 2);
        return s;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ch_fault_vld = '0; ch_fault_cmpl = '0; ch_kill = '0; ch_fault_code = '0;
        mgr_fault_vld = 1'b0; mgr_fault_code = '0;
    endtask

    // compute expected next state from current model and current inputs
    task automatic model_step();
        logic any_now, any_next, fev, kev;
        any_now = (|model_sum()) | m_mgr;
        fev = 1'b0; kev = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_fault_vld[c]) begin
                m_ft[c] |= FT_W'(1) << ch_fault_code[c*CODE_W +: CODE_W];
                m_st[c] = ch_fault_cmpl[c] ? 2 : 1;
                fev = 1'b1;
            end else if (ch_kill[c] && m_st[c] != 0) begin
                m_ft[c] = '0; m_st[c] = 0; kev = 1'b1;
            end
        end
        if (mgr_fault_vld) begin
            m_mft |= FT_W'(1) << mgr_fault_code;
            m_mgr = 1'b1; fev = 1'b1;
        end
        any_next = (|model_sum()) | m_mgr;
        if (fev && !any_now) m_abort = 1'b1;
        else if (kev && !any_next) m_abort = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2"}, "ch_sum", 64'(ch_sum), 64'(model_sum()));
        chk({tag, " R2"}, "ch_faulting", 64'(ch_faulting), 64'(model_sum()));
        chk({tag, " R2"}, "ch_cmpl_state", 64'(ch_cmpl_state), 64'(model_cmpl()));
        chk({tag, " R3"}, "mgr_ftype", 64'(mgr_ftype), 64'(m_mft));
        chk({tag, " R3"}, "mgr_sum", 64'(mgr_sum), 64'(m_mgr));
        chk({tag, " R3"}, "mgr_faulting", 64'(mgr_faulting), 64'(m_mgr));
        chk({tag, " R4/R6 abort"}, "abort_irq", 64'(abort_irq), 64'(m_abort));
        for (int c = 0; c < NUM_CH; c++) begin
            ch_rd_sel = IDX_W'(c);
            #0.1;
            chk({tag, " R1 R10"}, $sformatf("ch_rd_ftype[%0d]", c), 64'(ch_rd_ftype), 64'(m_ft[c]));
        end
    endtask

    // inputs already driven (after negedge); clock one edge, then compare
    task automatic step(input string tag);
        model_step();
        @(posedge clk); #1;
        clear_inputs();
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin m_ft[c] = '0; m_st[c] = 0; end
        m_mft = '0; m_mgr = 1'b0; m_abort = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        compare_all("R7 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ch_fault(input int c, input int code, input logic cmpl);
        ch_fault_vld[c] = 1'b1;
        ch_fault_code[c*CODE_W +: CODE_W] = CODE_W'(code);
        ch_fault_cmpl[c] = cmpl;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231016));
        rst_n = 1'b0; ch_rd_sel = '0;
        clear_inputs();
        @(negedge clk);
        do_reset();

        // R9: kill on idle channel
        ch_kill = 8'h0F; step("R9 idle kill");
        chk("R9", "abort after idle kill", 64'(abort_irq), 64'd0);

        // R4: first fault raises abort
        ch_fault(2, 7, 1'b0); step("R4 first fault");
        chk("R4", "abort", 64'(abort_irq), 64'd1);
        // R1: second code on same channel keeps first bit, completing flag
        ch_fault(2, 31, 1'b1); step("R1 accumulate");
        chk("R1", "ch2 bits", 64'(m_ft[2]), 64'h8000_0080);
        ch_fault(5, 0, 1'b0); step("R1 second channel");
        // R8: fault and kill together on channel 5
        ch_fault(5, 3, 1'b0); ch_kill[5] = 1'b1; step("R8 fault beats kill");
        chk("R8", "ch5 faulting", 64'(ch_faulting[5]), 64'd1);
        // R5/R6: kill channel 2, channel 5 still pending
        ch_kill[2] = 1'b1; step("R5 kill one");
        chk("R6", "abort holds", 64'(abort_irq), 64'd1);
        // R5/R6: kill last channel drops abort
        ch_kill[5] = 1'b1; step("R6 kill last");
        chk("R6", "abort dropped", 64'(abort_irq), 64'd0);
        // R3: manager fault raises abort; channel kills cannot drop it
        mgr_fault_vld = 1'b1; mgr_fault_code = 5'd4; step("R3 mgr fault");
        ch_fault(0, 1, 1'b0); step("R3 ch fault with mgr");
        ch_kill[0] = 1'b1; step("R6 kill with mgr pending");
        chk("R6", "abort held by manager", 64'(abort_irq), 64'd1);
        do_reset();

        // random phase
        for (int blk = 0; blk < 6; blk++) begin
            for (int n = 0; n < 150; n++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (($urandom % 8) == 0) ch_fault(c, int'($urandom % FT_W), 1'($urandom % 2));
                    ch_kill[c] = (($urandom % 4) == 0);
                end
                if (($urandom % 300) == 0) begin
                    mgr_fault_vld = 1'b1;
                    mgr_fault_code = CODE_W'($urandom % FT_W);
                end
                step("random R1 R2 R5 R8 R9");
            end
            do_reset();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule